// File: doc/BRIEF.md
# Channel-Status Bit Access Port

This block is the host-side register port of a digital audio interface. It holds a small store of channel-status bits (32 by default) and gives the host access to them one bit at a time through two byte-wide registers. A mode latch, set through the control register, decides whether a write to the data register stores a bit or only selects a bit for a later read.

The same control register, when read, reports the state of the receiver: whether a recovered clock is present, whether data is present, and a two-bit sample-rate code. These receiver indications arrive as inputs from the receiver logic. The host bus is synchronous, with one address bit, separate write and read strobes and byte-wide data. Read data appears one cycle after the read strobe.

Top module: `chstat_reg_port`

## Requirements
- R1: After reset the port is in store mode, every channel-status bit is 0 and `host_rdata` is 0.
- R2: A write to address 0 with `host_wdata[0]`=1 selects fetch mode, and with `host_wdata[0]`=0 selects store mode. The other bits of that byte are ignored.
- R3: In store mode, a write to address 1 copies `host_wdata[7]` into the channel-status bit numbered `host_wdata[4:0]`. Bits 6:5 of the byte do not affect which bit is selected, and no other channel-status bit changes.
- R4: In fetch mode, a write to address 1 records `host_wdata[4:0]` as the fetch index and leaves every channel-status bit unchanged.
- R5: In fetch mode, a read of address 1 returns the channel-status bit at the recorded fetch index in `host_rdata[7]`, with bits 6:0 at 0. The data is valid in the cycle after the read strobe.
- R6: In store mode, a read of address 1 returns 0 in all eight bits.
- R7: A read of address 0 returns the clock-present flag in bit 0, the data-present flag in bit 1 and the rate code in bits 3:2. Bits 7:4 read as 0. The rate code is 00 for 32 kHz, 01 for 44.1 kHz, 10 for 48 kHz and 11 for unknown.
- R8: When the clock-present input is low, the rate field of the status byte reads 11, whatever the rate input holds.
- R9: In any cycle that follows a cycle without a read strobe, `host_rdata` is 0.
- R10: Channel-status bit 0 (the consumer/professional flag) is stored and fetched like every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 1 | Register select: 0 control/status, 1 data |
| host_we | input | 1 | Write strobe |
| host_re | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, one cycle after the read strobe |
| rx_clk_ok | input | 1 | Receiver has a recovered clock |
| rx_data_ok | input | 1 | Receiver sees valid data |
| rx_rate | input | 2 | Rate code from the receiver (00/01/10/11) |

## Verification
The bench uses the default parameters: a 32-bit store addressed by a 5-bit index inside a byte-wide bus. With these values it can walk every index, including 0 (the professional flag) and 31, and it can set index bits 6:5 to confirm that they are masked off. A full 32-bit pattern is stored and then fetched back. The status byte is read under every combination of the clock, data and rate inputs, so the forced-unknown rate is exercised when the clock is absent.

// File: rtl/chstat_pkg.sv
// Package: shared constants for the channel-status register port.
// Assumes: a single address bit selects between the two host registers.
package chstat_pkg;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    // Rate codes reported in the status byte
    localparam logic [1:0] RATE_32K    = 2'b00;
    localparam logic [1:0] RATE_44K1   = 2'b01;
    localparam logic [1:0] RATE_48K    = 2'b10;
    localparam logic [1:0] RATE_UNKNOWN = 2'b11;

    typedef enum logic {
        MODE_STORE = 1'b0,
        MODE_FETCH = 1'b1
    } port_mode_e;
endpackage

// File: rtl/chstat_mode_ctl.sv
// Module: mode latch and fetch-index register.
// Assumes: at most one register write per cycle; the index is the low IDX_W bits of the byte.
module chstat_mode_ctl
    import chstat_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    output port_mode_e        mode,
    output logic [IDX_W-1:0]  fetch_idx
);
    // Hold the store/fetch selection written through the control register
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MODE_STORE;
        else if (ctrl_wr)
            mode <= wdata[0] ? MODE_FETCH : MODE_STORE;
    end

    // Record the index of a data write made in fetch mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            fetch_idx <= '0;
        else if (data_wr && mode == MODE_FETCH)
            fetch_idx <= wdata[IDX_W-1:0];
    end
endmodule

// File: rtl/chstat_bit_store.sv
// Module: bit-addressed channel-status store with one write port and one read port.
// Assumes: NUM_BITS is no larger than 2**IDX_W.
module chstat_bit_store #(
    parameter int NUM_BITS = 32,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_bit,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic                rd_bit,
    output logic [NUM_BITS-1:0] bits_q
);
    // One flop per channel-status bit, each written only when its index is selected
    for (genvar g = 0; g < NUM_BITS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits_q[g] <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(g))
                bits_q[g] <= wr_bit;
        end
    end

    // Select the bit at the fetch index; an index beyond the store reads 0
    always_comb begin
        rd_bit = 1'b0;
        for (int i = 0; i < NUM_BITS; i++)
            if (rd_idx == IDX_W'(i))
                rd_bit = bits_q[i];
    end
endmodule

// File: rtl/chstat_status_fmt.sv
// Module: packs the receiver indications into the status byte.
// Assumes: the receiver inputs are already synchronous to clk.
module chstat_status_fmt
    import chstat_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_ok,
    input  logic              data_ok,
    input  logic [1:0]        rate,
    output logic [DATA_W-1:0] status
);
    // Place the flags and the rate field; the rate is unknown when there is no clock
    always_comb begin
        status      = '0;
        status[0]   = clk_ok;
        status[1]   = data_ok;
        status[3:2] = clk_ok ? rate : RATE_UNKNOWN;
    end
endmodule

// File: rtl/chstat_reg_port.sv
// Module: host register port for the channel-status bit store and receiver status.
// Assumes: one-cycle read latency; a read in the same cycle as a write sees the old state.
module chstat_reg_port
    import chstat_pkg::*;
#(
    parameter int NUM_BITS = 32,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_addr,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              rx_clk_ok,
    input  logic              rx_data_ok,
    input  logic [1:0]        rx_rate
);
    localparam int IDX_W   = $clog2(NUM_BITS);
    localparam int VAL_BIT = DATA_W - 1;

    logic                ctrl_wr, data_wr, store_wr;
    port_mode_e          mode;
    logic [IDX_W-1:0]    fetch_idx;
    logic                fetch_bit;
    logic [NUM_BITS-1:0] cs_bits;
    logic [DATA_W-1:0]   status_byte;
    logic [DATA_W-1:0]   data_byte;

    // Decode the host write strobes per register
    always_comb begin
        ctrl_wr  = host_we && host_addr == ADDR_CTRL;
        data_wr  = host_we && host_addr == ADDR_DATA;
        store_wr = data_wr && mode == MODE_STORE;
    end

    chstat_mode_ctl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .data_wr   (data_wr),
        .wdata     (host_wdata),
        .mode      (mode),
        .fetch_idx (fetch_idx)
    );

    chstat_bit_store #(.NUM_BITS(NUM_BITS), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (store_wr),
        .wr_idx (host_wdata[IDX_W-1:0]),
        .wr_bit (host_wdata[VAL_BIT]),
        .rd_idx (fetch_idx),
        .rd_bit (fetch_bit),
        .bits_q (cs_bits)
    );

    chstat_status_fmt #(.DATA_W(DATA_W)) u_status (
        .clk_ok  (rx_clk_ok),
        .data_ok (rx_data_ok),
        .rate    (rx_rate),
        .status  (status_byte)
    );

    // Form the data-register read value: the fetched bit in the top position in fetch mode
    always_comb begin
        data_byte          = '0;
        data_byte[VAL_BIT] = (mode == MODE_FETCH) ? fetch_bit : 1'b0;
    end

    // Register the read data; zero when no read was strobed
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= '0;
        else if (host_re)
            host_rdata <= (host_addr == ADDR_CTRL) ? status_byte : data_byte;
        else
            host_rdata <= '0;
    end
endmodule

// File: rtl/chstat_reg_port_chk.sv
// Module: assertion checker for chstat_reg_port, attached by bind.
// Assumes: the bound instance exposes mode and the store contents by name.
module chstat_reg_port_chk
    import chstat_pkg::*;
#(
    parameter int NUM_BITS = 32,
    parameter int DATA_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                host_addr,
    input logic                host_we,
    input logic                host_re,
    input logic [DATA_W-1:0]   host_rdata,
    input logic                rx_clk_ok,
    input logic                mode,
    input logic [NUM_BITS-1:0] cs_bits
);
    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_re |=> host_rdata == '0);

    // R7
    status_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && host_addr == ADDR_CTRL) |=> host_rdata[DATA_W-1:4] == '0);

    // R8
    no_clk_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && host_addr == ADDR_CTRL && !rx_clk_ok) |=> host_rdata[3:2] == RATE_UNKNOWN);

    // R5
    data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && host_addr == ADDR_DATA) |=> host_rdata[DATA_W-2:0] == '0);

    // R6
    store_mode_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && host_addr == ADDR_DATA && mode == MODE_STORE) |=> host_rdata == '0);

    // R4
    fetch_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == ADDR_DATA && mode == MODE_FETCH) |=> $stable(cs_bits));

    // R2
    ctrl_write_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_we || host_addr != ADDR_CTRL) |=> $stable(mode));
endmodule

bind chstat_reg_port chstat_reg_port_chk #(.NUM_BITS(NUM_BITS), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_rdata (host_rdata),
    .rx_clk_ok  (rx_clk_ok),
    .mode       (mode),
    .cs_bits    (cs_bits)
);

// File: tb/tb_chstat_reg_port.sv
// Directed bench for chstat_reg_port; one task per scenario.
module tb_chstat_reg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_addr = 1'b0;
    logic       host_we = 1'b0;
    logic       host_re = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       rx_clk_ok = 1'b0;
    logic       rx_data_ok = 1'b0;
    logic [1:0] rx_rate = 2'b00;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    chstat_reg_port dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_re    (host_re),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .rx_clk_ok  (rx_clk_ok),
        .rx_data_ok (rx_data_ok),
        .rx_rate    (rx_rate)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_re = 1'b1;
        @(negedge clk);
        host_re = 1'b0;
        d = host_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 rdata", host_rdata, 8'h00);
        rx_clk_ok = 1'b1; rx_data_ok = 1'b0; rx_rate = 2'b10;
        rd(1'b1, v);
        check("R1 store mode data read", v, 8'h00);
        wr(1'b0, 8'h01);
        for (int i = 0; i < 32; i++) begin
            wr(1'b1, 8'(i));
            rd(1'b1, v);
            check("R1 bit cleared", v, 8'h00);
        end
        wr(1'b0, 8'h00);
    endtask

    task automatic t_store_fetch(input logic [31:0] pat);
        logic [7:0] v;
        wr(1'b0, 8'hFE);   // bit0=0 -> store mode, other bits ignored (R2)
        for (int i = 0; i < 32; i++)
            wr(1'b1, {pat[i], 2'b00, 5'(i)});
        rd(1'b1, v);
        check("R6 store mode read", v, 8'h00);
        wr(1'b0, 8'h01);   // fetch mode (R2)
        for (int i = 0; i < 32; i++) begin
            wr(1'b1, 8'(i));
            rd(1'b1, v);
            check(i == 0 ? "R10 flag bit" : "R3 R5 fetched bit", v, {pat[i], 7'h00});
        end
    endtask

    task automatic t_index_mask();
        logic [7:0] v;
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h07);          // clear bit 7
        wr(1'b1, 8'h03);          // clear bit 3
        wr(1'b1, 8'hE3);          // bit7=1, bits 6:5 set, index 3
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h03);
        rd(1'b1, v);
        check("R3 masked index sets bit 3", v, 8'h80);
        wr(1'b1, 8'h07);
        rd(1'b1, v);
        check("R3 neighbour bit 7 untouched", v, 8'h00);
    endtask

    task automatic t_fetch_write_no_store();
        logic [7:0] v;
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h05);          // bit 5 = 0
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h85);          // fetch mode: only records index 5
        rd(1'b1, v);
        check("R4 fetch-mode write leaves bit", v, 8'h00);
        wr(1'b1, 8'h1F);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h9F);          // set bit 31
        wr(1'b0, 8'h01);
        rd(1'b1, v);              // index 31 still recorded
        check("R4 index kept across mode change", v, 8'h80);
    endtask

    task automatic t_status();
        logic [7:0] v;
        logic [7:0] exp;
        for (int c = 0; c < 16; c++) begin
            rx_clk_ok  = c[0];
            rx_data_ok = c[1];
            rx_rate    = c[3:2];
            rd(1'b0, v);
            exp = {4'h0, (c[0] ? c[3:2] : 2'b11), c[1], c[0]};
            check(c[0] ? "R7 status byte" : "R8 no clock rate", v, exp);
        end
    endtask

    task automatic t_idle_zero();
        logic [7:0] v;
        rx_clk_ok = 1'b1; rx_data_ok = 1'b1; rx_rate = 2'b01;
        rd(1'b0, v);
        check("R7 status before idle", v, 8'h07);
        @(negedge clk);
        check("R9 idle rdata", host_rdata, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_store_fetch(32'hA5C3_1E69);
        t_store_fetch(32'h5A3C_E196);
        t_index_mask();
        t_fetch_write_no_store();
        t_status();
        t_idle_zero();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule